// File: doc/BRIEF.md
# Sub-Word Register Bank

This block holds eight 32-bit general registers: four data registers, two pointer registers and two index registers. One write port and two independent read ports reach them, and every access names a register and an access size. A write of a 32-bit value replaces the whole register. A 16-bit or 8-bit write replaces only the byte lanes it addresses, and every other bit keeps its old value.

Each data register offers two 8-bit views: the least significant byte and the byte just above it. The pointer and index registers do not have 8-bit views. An 8-bit write aimed at one of them is refused, and it raises a flag instead. An 8-bit read of one of them returns zero and raises that port's error flag.

Reads are combinational. A read returns the selected view zero-extended to 32 bits. A read of the register being written in the same cycle sees the merged value that the write will store.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset, active high, clears all eight registers to zero.
- R2: A write with size code 3 (dword) stores all 32 bits of `wrData`, and a dword read returns all 32 bits.
- R3: A write with size code 2 (word) stores `wrData[15:0]` into bits 15:0 and leaves bits 31:16 unchanged.
- R4: A write with size code 0 (low byte) stores `wrData[7:0]` into bits 7:0 of a data register (select 0 to 3) and leaves bits 31:8 unchanged.
- R5: A write with size code 1 (high byte) stores `wrData[7:0]` into bits 15:8 of a data register and leaves bits 31:16 and 7:0 unchanged.
- R6: A read is zero-extended. Code 0 returns bits 7:0, code 1 returns bits 15:8, code 2 returns bits 15:0 and code 3 returns the full register.
- R7: An enabled write with size code 0 or 1 to select 4 to 7 (pointer or index) drives `wrReject` high in the same cycle and changes no register.
- R8: A read with size code 0 or 1 of select 4 to 7 returns zero and drives that port's error flag high. Every other read drives the flag low.
- R9: A read of the register being written in that cycle returns the merged value the write will store (write-first).
- R10: A register keeps its value in any cycle in which it is not written, and the two read ports operate independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrSel | input | 3 | Write register select (0-3 data, 4-7 pointer/index) |
| wrSize | input | 2 | Write size code (0 low byte, 1 high byte, 2 word, 3 dword) |
| wrData | input | 32 | Write data, right-aligned |
| wrReject | output | 1 | Write refused: byte size on pointer/index register |
| rdSelA | input | 3 | Read port A register select |
| rdSizeA | input | 2 | Read port A size code |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdErrA | output | 1 | Read port A illegal size |
| rdSelB | input | 3 | Read port B register select |
| rdSizeB | input | 2 | Read port B size code |
| rdDataB | output | 32 | Read port B data, zero-extended |
| rdErrB | output | 1 | Read port B illegal size |

## Verification
One data register is built up in stages: first a dword write, then a word write, then a low-byte write and then a high-byte write. Each stage uses data whose other bytes are all ones. A wrong lane mask or a wrong lane shift therefore shows up as a changed byte at the next full read. The same register is then read at all four sizes. This separates the low-byte view from the high-byte view and from the zero-extension. Byte writes and byte reads are aimed at a pointer register that holds a known pattern, which shows that the refusal leaves its contents untouched. The same-cycle tests read on both ports while a full write and a partial write are in progress. This separates the write-first merge from a plain registered read.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
  localparam int unsigned REG_COUNT  = 8;
  localparam int unsigned BYTE_REGS  = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LANES      = DATA_W / 8;
  localparam int unsigned SEL_W      = $clog2(REG_COUNT);
  localparam int unsigned RD_PORTS   = 2;

  typedef enum logic [1:0] {
    SZ_LO8 = 2'd0,
    SZ_HI8 = 2'd1,
    SZ_W16 = 2'd2,
    SZ_D32 = 2'd3
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [REG_COUNT-1:0] regHit;
    logic [LANES-1:0]     laneEn;
    logic [DATA_W-1:0]    laneData;
  } wrStrobe_t;

  // Byte views exist only on the low-numbered registers
  function automatic logic sizeAllowed(logic [SEL_W-1:0] sel, accSize_e sz);
    return (32'(sel) < BYTE_REGS) || (sz == SZ_W16) || (sz == SZ_D32);
  endfunction
endpackage

// File: rtl/gpr_bank_ctrl.sv
module gpr_bank_ctrl
  import gpr_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  accSize_e          wrSize,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobe_t         strobe,
  output logic              reject
);
  logic legal;
  logic accept;

  always_comb begin
    legal  = sizeAllowed(wrSel, wrSize);
    reject = wrEn && !legal;
    accept = wrEn && legal;

    strobe.regHit = '0;
    if (accept) strobe.regHit[wrSel] = 1'b1;

    strobe.laneEn   = '0;
    strobe.laneData = '0;
    unique case (wrSize)
      SZ_LO8: begin
        strobe.laneEn[0]      = 1'b1;
        strobe.laneData[7:0]  = wrData[7:0];
      end
      SZ_HI8: begin
        strobe.laneEn[1]      = 1'b1;
        strobe.laneData[15:8] = wrData[7:0];
      end
      SZ_W16: begin
        strobe.laneEn[1:0]    = 2'b11;
        strobe.laneData[15:0] = wrData[15:0];
      end
      default: begin
        strobe.laneEn         = '1;
        strobe.laneData       = wrData;
      end
    endcase
  end
endmodule

// File: rtl/gpr_bank_dp.sv
module gpr_bank_dp
  import gpr_bank_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  wrStrobe_t                        strobe,
  input  logic [RD_PORTS-1:0][SEL_W-1:0]   rdSel,
  input  logic [RD_PORTS-1:0][1:0]         rdSize,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdData,
  output logic [RD_PORTS-1:0]              rdErr
);
  logic [REG_COUNT-1:0][DATA_W-1:0] regQ;
  logic [REG_COUNT-1:0][DATA_W-1:0] nextVal;

  function automatic logic [DATA_W-1:0] shapeView(logic [DATA_W-1:0] v, accSize_e sz);
    logic [DATA_W-1:0] r;
    r = '0;
    unique case (sz)
      SZ_LO8:  r[7:0]  = v[7:0];
      SZ_HI8:  r[7:0]  = v[15:8];
      SZ_W16:  r[15:0] = v[15:0];
      default: r       = v;
    endcase
    return r;
  endfunction

  // Per-lane merge of the write into each register
  for (genvar g = 0; g < REG_COUNT; g++) begin : gRegs
    for (genvar l = 0; l < LANES; l++) begin : gLanes
      assign nextVal[g][l*8 +: 8] = (strobe.regHit[g] && strobe.laneEn[l])
                                    ? strobe.laneData[l*8 +: 8]
                                    : regQ[g][l*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) regQ <= '0;
    else     regQ <= nextVal;
  end

  // Read ports see the merged value (write-first)
  for (genvar p = 0; p < RD_PORTS; p++) begin : gRead
    always_comb begin
      if (sizeAllowed(rdSel[p], accSize_e'(rdSize[p]))) begin
        rdData[p] = shapeView(nextVal[rdSel[p]], accSize_e'(rdSize[p]));
        rdErr[p]  = 1'b0;
      end else begin
        rdData[p] = '0;
        rdErr[p]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [1:0]        wrSize,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReject,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [1:0]        rdSizeA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdErrA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic [1:0]        rdSizeB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdErrB
);
  wrStrobe_t                        wrStb;
  logic [RD_PORTS-1:0][DATA_W-1:0]  rdDataArr;
  logic [RD_PORTS-1:0]              rdErrArr;

  gpr_bank_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrSize (accSize_e'(wrSize)),
    .wrData (wrData),
    .strobe (wrStb),
    .reject (wrReject)
  );

  gpr_bank_dp u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (wrStb),
    .rdSel  ({rdSelB, rdSelA}),
    .rdSize ({rdSizeB, rdSizeA}),
    .rdData (rdDataArr),
    .rdErr  (rdErrArr)
  );

  assign rdDataA = rdDataArr[0];
  assign rdDataB = rdDataArr[1];
  assign rdErrA  = rdErrArr[0];
  assign rdErrB  = rdErrArr[1];
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk
  import gpr_bank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [SEL_W-1:0]  wrSel,
  input logic [1:0]        wrSize,
  input logic [DATA_W-1:0] wrData,
  input logic              wrReject,
  input logic [SEL_W-1:0]  rdSelA,
  input logic [1:0]        rdSizeA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdErrA,
  input logic [REG_COUNT-1:0] regHit
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wrEn && !rdErrA) |-> (rdDataA == '0));

  p_byte_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (rdSizeA == 2'd0 || rdSizeA == 2'd1) |-> (rdDataA[DATA_W-1:8] == '0));

  p_word_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (rdSizeA == 2'd2) |-> (rdDataA[DATA_W-1:16] == '0));

  p_reject_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    wrReject |-> (regHit == '0));

  p_reject_cause_r7: assert property (@(posedge clk) disable iff (rst)
    wrReject |-> (wrEn && wrSel >= 3'd4 && wrSize[1] == 1'b0));

  p_illegal_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rdSelA >= 3'd4 && rdSizeA[1] == 1'b0) |-> (rdErrA && rdDataA == '0));

  p_bypass_full_r9: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSize == 2'd3 && rdSelA == wrSel && rdSizeA == 2'd3) |-> (rdDataA == wrData));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && !wrEn && $stable(rdSelA) && $stable(rdSizeA))
      |-> $stable(rdDataA));
endmodule

bind gpr_bank gpr_bank_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrSize   (wrSize),
  .wrData   (wrData),
  .wrReject (wrReject),
  .rdSelA   (rdSelA),
  .rdSizeA  (rdSizeA),
  .rdDataA  (rdDataA),
  .rdErrA   (rdErrA),
  .regHit   (wrStb.regHit)
);

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        wrReject;
  logic [2:0]  rdSelA = '0;
  logic [1:0]  rdSizeA = 2'd3;
  logic [31:0] rdDataA;
  logic        rdErrA;
  logic [2:0]  rdSelB = '0;
  logic [1:0]  rdSizeB = 2'd3;
  logic [31:0] rdDataB;
  logic        rdErrB;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpr_bank u_dut (
    .clk(clk), .rst(rst),
    .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrData(wrData), .wrReject(wrReject),
    .rdSelA(rdSelA), .rdSizeA(rdSizeA), .rdDataA(rdDataA), .rdErrA(rdErrA),
    .rdSelB(rdSelB), .rdSizeB(rdSizeB), .rdDataB(rdDataB), .rdErrB(rdErrB)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] sel, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrSize = sz; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic readA(logic [2:0] sel, logic [1:0] sz, string req, logic [31:0] exp);
    rdSelA = sel; rdSizeA = sz;
    #2;
    check(req, rdDataA, exp);
  endtask

  task automatic readB(logic [2:0] sel, logic [1:0] sz, string req, logic [31:0] exp);
    rdSelB = sel; rdSizeB = sz;
    #2;
    check(req, rdDataB, exp);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) readA(3'(i), 2'd3, "R1 reset clear", 32'h0);
  endtask

  task automatic testDword();
    doWrite(3'd0, 2'd3, 32'h1122_3344);
    doWrite(3'd7, 2'd3, 32'hDEAD_BEEF);
    readA(3'd0, 2'd3, "R2 dword reg0", 32'h1122_3344);
    readB(3'd7, 2'd3, "R2 dword reg7 portB", 32'hDEAD_BEEF);
    readA(3'd1, 2'd3, "R10 untouched reg1", 32'h0);
  endtask

  task automatic testPartial();
    doWrite(3'd0, 2'd2, 32'hFFFF_AAAA);
    readA(3'd0, 2'd3, "R3 word merge", 32'h1122_AAAA);
    doWrite(3'd0, 2'd0, 32'hFFFF_FF55);
    readA(3'd0, 2'd3, "R4 low byte merge", 32'h1122_AA55);
    doWrite(3'd0, 2'd1, 32'hFFFF_FF77);
    readA(3'd0, 2'd3, "R5 high byte merge", 32'h1122_7755);
    doWrite(3'd5, 2'd3, 32'hA5A5_A5A5);
    doWrite(3'd5, 2'd2, 32'hFFFF_1234);
    readB(3'd5, 2'd3, "R3 word on pointer reg", 32'hA5A5_1234);
  endtask

  task automatic testViews();
    readA(3'd0, 2'd0, "R6 low byte view", 32'h0000_0055);
    readA(3'd0, 2'd1, "R6 high byte view", 32'h0000_0077);
    readA(3'd0, 2'd2, "R6 word view", 32'h0000_7755);
    readB(3'd7, 2'd2, "R6 word view reg7", 32'h0000_BEEF);
    check("R8 legal read flag", 32'(rdErrB), 32'h0);
  endtask

  task automatic testReject();
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd7; wrSize = 2'd0; wrData = 32'h0000_0000;
    #2 check("R7 reject flag low-byte", 32'(wrReject), 32'h1);
    @(posedge clk);
    #1 wrSize = 2'd1;
    #2 check("R7 reject flag high-byte", 32'(wrReject), 32'h1);
    @(posedge clk);
    #1 wrEn = 1'b0;
    #1 check("R7 reject flag clear when idle", 32'(wrReject), 32'h0);
    readA(3'd7, 2'd3, "R7 reg7 unchanged", 32'hDEAD_BEEF);
  endtask

  task automatic testIllegalRead();
    readA(3'd7, 2'd0, "R8 byte read of reg7 data", 32'h0);
    check("R8 byte read of reg7 flag", 32'(rdErrA), 32'h1);
    readB(3'd4, 2'd1, "R8 high read of reg4 data", 32'h0);
    check("R8 high read of reg4 flag", 32'(rdErrB), 32'h1);
    readA(3'd7, 2'd2, "R8 word read of reg7", 32'h0000_BEEF);
    check("R8 word read flag", 32'(rdErrA), 32'h0);
  endtask

  task automatic testBypass();
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd2; wrSize = 2'd3; wrData = 32'hCAFE_F00D;
    rdSelA = 3'd2; rdSizeA = 2'd3; rdSelB = 3'd2; rdSizeB = 2'd2;
    #2;
    check("R9 bypass dword portA", rdDataA, 32'hCAFE_F00D);
    check("R9 bypass word portB", rdDataB, 32'h0000_F00D);
    @(posedge clk);
    #1 wrSize = 2'd1; wrData = 32'h0000_0099; rdSizeB = 2'd3;
    #2;
    check("R9 bypass high-byte merge", rdDataB, 32'hCAFE_990D);
    @(posedge clk);
    #1 wrEn = 1'b0;
    readA(3'd2, 2'd3, "R9 stored after merge", 32'hCAFE_990D);
  endtask

  initial begin
    testReset();
    testDword();
    testPartial();
    testViews();
    testReject();
    testIllegalRead();
    testBypass();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule